// File: doc/BRIEF.md
# Sequential Modular Multiplier, Low Bit First

The block computes `(A * B) mod P` for unsigned operands of a parameterised width `W`. A one-cycle `start` strobe captures the multiplicand, the multiplier and the modulus. The block then walks the multiplier one bit per clock, starting at bit 0.

Two registers carry the state from step to step. The partial remainder holds `A * 2^i mod P`, and the accumulator holds the sum of the remainders already selected by the multiplier bits, reduced modulo `P`. The block has one doubling stage and one modular adder, and every step reuses them. Each of the two reduces its sum by a single conditional subtraction of `P`, so no precomputed constant is needed.

No value in the datapath grows past one bit above the modulus width. When the last bit has been used, the block raises `done` for one cycle and holds the result until the next accepted start. The caller must supply `A < P` and `P >= 2`.

Top module: `modmul_lsb`

## Requirements
- R1: For any `P >= 2` and `A < P`, the `result` presented with `done` equals `(A * B) mod P`, with B taken as a `W`-bit unsigned value.
- R2: `done` is high for exactly one cycle. It rises in the cycle that follows the `W-1`-th rising edge after the edge that accepted `start`.
- R3: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high. `busy` is low while `done` is high.
- R4: A `start` that arrives while `busy` is high is ignored. Its operands have no effect on the result of the operation in progress.
- R5: `result` changes only in a cycle where `done` is high. It holds its value while the input operands change and no start is accepted.
- R6: While reset (`rst_n` low) is applied, `busy`, `done` and `result` are all zero.
- R7: The result is correct in these cases: A=25, B=22, P=26 gives 4, and A=27, B=23, P=35 gives 26.
- R8: A modulus of all ones (`2^W - 1`) with operands at `P-1` gives the correct result with no overflow inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operand capture strobe; honoured only while idle |
| a_in | input | W | Multiplicand, must be below the modulus |
| b_in | input | W | Multiplier |
| p_in | input | W | Modulus, at least 2 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Product modulo P, held until the next operation completes |

## Verification
Suppose a remainder in the doubling stage or the accumulator is wrong at some step. The fault cannot cancel out: every later step builds on that value, so `result` is wrong at the next `done`, `W-1` cycles after the start at most. A fault in the step counter or the control state shows up differently. Either `done` rises in the wrong cycle, or `busy` and `done` overlap, and both can be seen on the first operation. The sweep covers every modulus, every multiplicand below that modulus and every multiplier at a width of five bits, so a reduction decision that goes the wrong way for any single value pair reaches the ports.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mm_state_e;
endpackage

// File: rtl/mm_cond_sub.sv
// Reduce a sum known to be below 2*P: subtract P once when the sum reaches P.
module mm_cond_sub #(
  parameter int W = 8
) (
  input  logic [W:0]   sum_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] red_o,
  output logic         ge_o
);
  localparam int XW = W + 2;

  // Adds the ones' complement of P plus one; the top carry flags sum >= P.
  function automatic logic [XW-1:0] sub_mod(input logic [W:0] s, input logic [W-1:0] m);
    logic [XW-1:0] lhs;
    logic [XW-1:0] rhs;
    lhs = {1'b0, s};
    rhs = {1'b0, 1'b1, ~m};
    return lhs + rhs + XW'(1);
  endfunction

  logic [XW-1:0] diff;

  always_comb begin
    diff  = sub_mod(sum_i, mod_i);
    ge_o  = diff[XW-1];
    red_o = ge_o ? diff[W-1:0] : sum_i[W-1:0];
  end
endmodule

// File: rtl/mm_dbl_stage.sv
// Partial remainder stage: r_next = (2 * r) mod P.
module mm_dbl_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] rem_o,
  output logic         ge_o
);
  logic [W:0] twice;

  assign twice = {rem_i, 1'b0};

  mm_cond_sub #(.W(W)) u_red (
    .sum_i (twice),
    .mod_i (mod_i),
    .red_o (rem_o),
    .ge_o  (ge_o)
  );
endmodule

// File: rtl/mm_mod_add.sv
// Accumulating modular adder: acc + add (mod P) when enabled, acc otherwise.
module mm_mod_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] add_i,
  input  logic         en_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] sum_o,
  output logic         ge_o
);
  logic [W:0]   raw;
  logic [W-1:0] red;

  assign raw = {1'b0, acc_i} + {1'b0, add_i};

  mm_cond_sub #(.W(W)) u_red (
    .sum_i (raw),
    .mod_i (mod_i),
    .red_o (red),
    .ge_o  (ge_o)
  );

  assign sum_o = en_i ? red : acc_i;
endmodule

// File: rtl/mm_ctrl.sv
// Control: accepts start while idle, counts W-1 steps, pulses done.
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W) + 1;

  mm_state_e     state_q;
  logic [CW-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign last_o = step_o && (cnt_q == CW'(1));
  assign busy_o = step_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= CW'(W - 1);
      end else if (step_o) begin
        cnt_q <= cnt_q - CW'(1);
        if (last_o) state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/modmul_lsb.sv
module modmul_lsb #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] p_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  // Operand and state registers
  logic [W-1:0] p_q;
  logic [W-1:0] b_q;
  logic [W-1:0] pr_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] res_q;

  // Named control events
  logic ld_evt;
  logic step_evt;
  logic fin_evt;

  // Datapath wires
  logic [W-1:0] dbl_src;
  logic [W-1:0] dbl_mod;
  logic [W-1:0] dbl_out;
  logic         dbl_ge;
  logic [W-1:0] add_out;
  logic         add_ge;
  logic         take_bit;

  mm_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .load_o  (ld_evt),
    .step_o  (step_evt),
    .last_o  (fin_evt),
    .busy_o  (busy),
    .done_o  (done)
  );

  // On load the doubling stage works on A and the incoming modulus.
  assign dbl_src = ld_evt ? a_in : pr_q;
  assign dbl_mod = ld_evt ? p_in : p_q;

  mm_dbl_stage #(.W(W)) u_dbl (
    .rem_i (dbl_src),
    .mod_i (dbl_mod),
    .rem_o (dbl_out),
    .ge_o  (dbl_ge)
  );

  // The bit that comes into position 0 after this step's shift.
  assign take_bit = b_q[1];

  mm_mod_add #(.W(W)) u_add (
    .acc_i (acc_q),
    .add_i (pr_q),
    .en_i  (take_bit),
    .mod_i (p_q),
    .sum_o (add_out),
    .ge_o  (add_ge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q   <= '0;
      b_q   <= '0;
      pr_q  <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else if (ld_evt) begin
      p_q   <= p_in;
      b_q   <= b_in;
      pr_q  <= dbl_out;
      acc_q <= b_in[0] ? a_in : '0;
    end else if (step_evt) begin
      b_q   <= b_q >> 1;
      pr_q  <= dbl_out;
      acc_q <= add_out;
      if (fin_evt) res_q <= add_out;
    end
  end

  assign result = res_q;
endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] p_q,
  input logic [W-1:0] pr_q,
  input logic [W-1:0] acc_q
);
  logic [15:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (start && !busy) lat_q <= 16'd1;
    else if (busy) lat_q <= lat_q + 16'd1;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat_q == 16'(W)));
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));
  // R4
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(p_q));
  // R1
  rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (pr_q < p_q && acc_q < p_q));
endmodule

bind modmul_lsb mm_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result),
  .p_q    (p_q),
  .pr_q   (pr_q),
  .acc_q  (acc_q)
);

// File: tb/modmul_lsb_tb.sv
module modmul_lsb_tb;
  localparam int W5 = 5;
  localparam int W8 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic          s_start = 1'b0;
  logic [W5-1:0] s_a = '0, s_b = '0, s_p = '0;
  logic          s_busy, s_done;
  logic [W5-1:0] s_res;

  logic          t_start = 1'b0;
  logic [W8-1:0] t_a = '0, t_b = '0, t_p = '0;
  logic          t_busy, t_done;
  logic [W8-1:0] t_res;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;
  int cyc = 0;

  always #4 clk = ~clk;

  modmul_lsb #(.W(W5)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(s_start), .a_in(s_a), .b_in(s_b), .p_in(s_p),
    .busy(s_busy), .done(s_done), .result(s_res)
  );

  modmul_lsb #(.W(W8)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .start(t_start), .a_in(t_a), .b_in(t_b), .p_in(t_p),
    .busy(t_busy), .done(t_done), .result(t_res)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // One full operation on the 5-bit instance, starting at a falling edge.
  task automatic op5(input int a, input int b, input int p);
    int exp;
    exp = (a * b) % p;
    s_a = W5'(a); s_b = W5'(b); s_p = W5'(p); s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    chk(s_busy == 1'b1, "R3", int'(s_busy), 1);
    repeat (W5 - 2) @(negedge clk);
    chk(s_done == 1'b0, "R2", int'(s_done), 0);
    @(negedge clk);
    chk(s_done == 1'b1, "R2", int'(s_done), 1);
    chk(s_busy == 1'b0, "R3", int'(s_busy), 0);
    chk(int'(s_res) == exp, "R1", int'(s_res), exp);
    @(negedge clk);
    chk(s_done == 1'b0, "R2", int'(s_done), 0);
  endtask

  task automatic op8(input int a, input int b, input int p, input string req);
    int exp;
    exp = (a * b) % p;
    t_a = W8'(a); t_b = W8'(b); t_p = W8'(p); t_start = 1'b1;
    @(negedge clk);
    t_start = 1'b0;
    repeat (W8 - 1) @(negedge clk);
    chk(t_done == 1'b1, req, int'(t_done), 1);
    chk(int'(t_res) == exp, req, int'(t_res), exp);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
      finish_up();
    end
  end

  initial begin
    int hold;
    int lfsr;
    // R6: reset state
    repeat (3) @(negedge clk);
    chk(s_busy == 1'b0, "R6", int'(s_busy), 0);
    chk(s_done == 1'b0, "R6", int'(s_done), 0);
    chk(s_res == '0, "R6", int'(s_res), 0);
    chk(t_res == '0, "R6", int'(t_res), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: worked cases
    op8(25, 22, 26, "R7");
    op8(27, 23, 35, "R7");
    op5(25, 22, 26);

    // R8: all-ones modulus and operands at P-1
    op8(254, 254, 255, "R8");
    op8(254, 255, 255, "R8");
    op8(128, 255, 255, "R8");
    op5(30, 30, 31);
    op5(30, 31, 31);

    // R4: start while busy is ignored
    s_a = 5'd3; s_b = 5'd5; s_p = 5'd7; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b1; s_a = 5'd6; s_b = 5'd6; s_p = 5'd29;
    @(negedge clk);
    s_start = 1'b0;
    repeat (W5 - 2) @(negedge clk);
    chk(s_done == 1'b1, "R4", int'(s_done), 1);
    chk(int'(s_res) == 1, "R4", int'(s_res), 1);
    @(negedge clk);

    // R5: result holds while operands change with no start
    hold = int'(s_res);
    s_a = 5'd17; s_b = 5'd31; s_p = 5'd19;
    repeat (4) @(negedge clk);
    chk(int'(s_res) == hold, "R5", int'(s_res), hold);
    chk(s_done == 1'b0, "R5", int'(s_done), 0);
    chk(s_busy == 1'b0, "R5", int'(s_busy), 0);

    // R1: exhaustive sweep at width 5
    for (int p = 2; p < 32; p++)
      for (int a = 0; a < p; a++)
        for (int b = 0; b < 32; b++)
          op5(a, b, p);

    // R1: pseudo-random cases at width 8
    lfsr = 32'h1d3a;
    for (int k = 0; k < 60; k++) begin
      int p8, a8, b8;
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      p8 = 2 + ((lfsr >> 8) % 254);
      a8 = (lfsr >> 3) % p8;
      b8 = (lfsr >> 16) & 8'hff;
      op8(a8, b8, p8, "R1");
    end

    finish_up();
  end
endmodule